// File: doc/BRIEF.md
# Two-Path Level Interrupt Controller

This block collects up to 32 level-sensitive interrupt lines and delivers each one to one of two processor inputs: a normal request line (`irq_o`) and a fast request line (`fiq_o`). Every line has an enable bit and a path-select bit. A line reaches an output only when it is asserted and enabled, and its select bit picks the output. The lines are expected to be synchronised to `clk` before they reach the block.

Software reaches the block through a simple 32-bit register port. It has a word address, a write strobe, write data and registered read data. Software can read the raw line levels and the enable and select masks. It can also read, for each path, the masked pending set and the number of the most urgent pending line. Urgency is fixed: the lowest line number wins. A priority word is kept for software and read back, but it does not change which line is reported.

Top module: `drc_intc`

## Requirements
- R1: After a synchronous active-low reset, the enable, select and priority words read 0, and both `irq_o` and `fiq_o` are low while all lines are low.
- R2: Read data is registered. The word chosen by `bus_word` in one cycle appears on `bus_rdata` after the next rising edge. Word map (`bus_word` = byte offset / 4): 0 raw levels, 1 enable, 2 path select, 3 normal-path pending, 4 fast-path pending, 5 priority, 6 normal-path top index, 7 fast-path top index.
- R3: Words 1, 2 and 5 take all 32 bits of `bus_wdata` on a cycle with `bus_we` high, and they read back unchanged.
- R4: Normal-path pending (word 3) equals raw & enable & ~select. Fast-path pending (word 4) equals raw & enable & select, so a select bit of 1 means the fast path.
- R5: `irq_o` is the OR of normal-path pending and `fiq_o` is the OR of fast-path pending. Both follow the line levels and the current register contents with no clock delay.
- R6: The top-index words (6 and 7) hold a valid flag in bit 31 and the lowest-numbered pending line of that path in bits 4:0. All other bits are 0.
- R7: When a path has nothing pending, its top-index word reads exactly 0.
- R8: Writes to words 0, 3, 4, 6 and 7 change no register and no output.
- R9: The value in the priority word has no effect on either top-index word or either output.
- R10: A line that is asserted but not enabled still shows in word 0, but it affects neither path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_lvl | input | 32 | Interrupt line levels, already synchronised |
| bus_word | input | 3 | Word address of the register access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Normal-path request |
| fiq_o | output | 1 | Fast-path request |

## Verification
A sweep drives a single line at a time across all 32 positions, once on each path. Every other select bit is set to the opposite path, so an inverted or swapped select bit, or a bad index bit, shows up at that exact position. Pseudo-random patterns then drive many lines at once with random enable, select and priority words. These catch faults in the lowest-index choice, in the masking and in any use of the priority word. Separate cases cover lines that are asserted but disabled, writes to read-only words, and a line change placed right after a read edge, which tells registered read data apart from combinational read data.

// File: rtl/drc_pkg.sv
// Shared definitions for the two-path interrupt controller.
// Assumes word-addressed register access (byte offset divided by four).
package drc_pkg;
    typedef enum logic [2:0] {
        W_RAW     = 3'd0,
        W_EN      = 3'd1,
        W_SEL     = 3'd2,
        W_NRM_ST  = 3'd3,
        W_FST_ST  = 3'd4,
        W_PRIO    = 3'd5,
        W_NRM_TOP = 3'd6,
        W_FST_TOP = 3'd7
    } word_e;
endpackage

// File: rtl/drc_regs.sv
// Writable configuration words: enable mask, path select mask, priority word.
// Assumes one write per cycle; any word outside these three is not stored here.
module drc_regs
    import drc_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  word_e              wr_word,
    input  logic [DATA_W-1:0]  wr_data,
    output logic [NUM_SRC-1:0] en_q,
    output logic [NUM_SRC-1:0] sel_q,
    output logic [DATA_W-1:0]  prio_q
);
    // Store the enable mask.
    always_ff @(posedge clk) begin
        if (!rst_n)                            en_q <= '0;
        else if (wr_en && wr_word == W_EN)     en_q <= wr_data[NUM_SRC-1:0];
    end

    // Store the path select mask.
    always_ff @(posedge clk) begin
        if (!rst_n)                            sel_q <= '0;
        else if (wr_en && wr_word == W_SEL)    sel_q <= wr_data[NUM_SRC-1:0];
    end

    // Store the priority word, kept for software only.
    always_ff @(posedge clk) begin
        if (!rst_n)                            prio_q <= '0;
        else if (wr_en && wr_word == W_PRIO)   prio_q <= wr_data;
    end

    // R8: without a matching write the enable mask does not move
    p_en_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_word == W_EN) |=> $stable(en_q));
    // R8: without a matching write the select mask does not move
    p_sel_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_word == W_SEL) |=> $stable(sel_q));
    // R3: a write to the priority word is stored
    p_prio_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_word == W_PRIO) |=> prio_q == $past(wr_data));
endmodule

// File: rtl/drc_route.sv
// Splits the enabled lines into the normal and fast paths and forms the request lines.
// Assumes the line levels are already synchronous to the clock.
module drc_route #(
    parameter int NUM_SRC = 32
) (
    input  logic [NUM_SRC-1:0] raw,
    input  logic [NUM_SRC-1:0] en,
    input  logic [NUM_SRC-1:0] sel,
    output logic [NUM_SRC-1:0] nrm_vec,
    output logic [NUM_SRC-1:0] fst_vec,
    output logic               nrm_any,
    output logic               fst_any
);
    // Steer each enabled line by its select bit: 1 goes to the fast path.
    always_comb begin
        for (int i = 0; i < NUM_SRC; i++) begin
            nrm_vec[i] = raw[i] & en[i] & ~sel[i];
            fst_vec[i] = raw[i] & en[i] &  sel[i];
        end
        nrm_any = |nrm_vec;
        fst_any = |fst_vec;
    end
endmodule

// File: rtl/drc_pick.sv
// Fixed-priority picker: reports the lowest-numbered set bit of a vector.
// Assumes NUM_SRC fits in IDX_W bits of index.
module drc_pick #(
    parameter int NUM_SRC = 32,
    parameter int IDX_W   = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] vec,
    output logic               valid,
    output logic [IDX_W-1:0]   idx
);
    // Scan from the top down so the lowest set bit is written last and wins.
    always_comb begin
        valid = 1'b0;
        idx   = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (vec[i]) begin
                valid = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

    // Mask of positions below the reported index, used only by the checks.
    logic [NUM_SRC-1:0] below;
    always_comb begin
        for (int i = 0; i < NUM_SRC; i++) below[i] = (IDX_W'(i) < idx);
    end

    // R6: the reported line is really pending
    p_top_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> vec[idx]);
    // R6: no lower-numbered line is pending
    p_top_lowest_r6: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (vec & below) == '0);
    // R7: with no valid flag the vector is empty and the index is 0
    p_top_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> (vec == '0 && idx == '0));
endmodule

// File: rtl/drc_intc.sv
// Two-path level interrupt controller top: register port, routing, two pickers.
// Assumes synchronised inputs; read data is registered, request lines are not.
module drc_intc
    import drc_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_lvl,
    input  logic [2:0]         bus_word,
    input  logic               bus_we,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               irq_o,
    output logic               fiq_o
);
    localparam int IDX_W = $clog2(NUM_SRC);

    word_e              word;
    logic [NUM_SRC-1:0] en_q, sel_q, nrm_vec, fst_vec;
    logic [DATA_W-1:0]  prio_q;
    logic               nrm_valid, fst_valid;
    logic [IDX_W-1:0]   nrm_idx, fst_idx;

    assign word = word_e'(bus_word);

    drc_regs #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_we), .wr_word(word),
        .wr_data(bus_wdata), .en_q(en_q), .sel_q(sel_q), .prio_q(prio_q)
    );

    drc_route #(.NUM_SRC(NUM_SRC)) u_route (
        .raw(src_lvl), .en(en_q), .sel(sel_q),
        .nrm_vec(nrm_vec), .fst_vec(fst_vec), .nrm_any(irq_o), .fst_any(fiq_o)
    );

    drc_pick #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_pick_nrm (
        .clk(clk), .rst_n(rst_n), .vec(nrm_vec), .valid(nrm_valid), .idx(nrm_idx)
    );

    drc_pick #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_pick_fst (
        .clk(clk), .rst_n(rst_n), .vec(fst_vec), .valid(fst_valid), .idx(fst_idx)
    );

    // Widen a line vector to a data word.
    function automatic logic [DATA_W-1:0] widen(input logic [NUM_SRC-1:0] v);
        logic [DATA_W-1:0] w;
        w = '0;
        w[NUM_SRC-1:0] = v;
        return w;
    endfunction

    // Pack a valid flag and an index into a top-index word.
    function automatic logic [DATA_W-1:0] top_word(input logic v, input logic [IDX_W-1:0] i);
        logic [DATA_W-1:0] w;
        w = '0;
        w[DATA_W-1]  = v;
        w[IDX_W-1:0] = i;
        return w;
    endfunction

    // Read multiplexer, registered so data follows the address by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) bus_rdata <= '0;
        else begin
            unique case (word)
                W_RAW:     bus_rdata <= widen(src_lvl);
                W_EN:      bus_rdata <= widen(en_q);
                W_SEL:     bus_rdata <= widen(sel_q);
                W_NRM_ST:  bus_rdata <= widen(nrm_vec);
                W_FST_ST:  bus_rdata <= widen(fst_vec);
                W_PRIO:    bus_rdata <= prio_q;
                W_NRM_TOP: bus_rdata <= top_word(nrm_valid, nrm_idx);
                W_FST_TOP: bus_rdata <= top_word(fst_valid, fst_idx);
                default:   bus_rdata <= '0;
            endcase
        end
    end

    // R2: raw levels appear on the read port one edge after being addressed
    p_read_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_word == 3'd0) |=> bus_rdata[NUM_SRC-1:0] == $past(src_lvl));
    // R5: the normal request line implies an enabled, normal-routed asserted line
    p_irq_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (src_lvl & en_q & ~sel_q) != '0);
    // R5: the fast request line implies an enabled, fast-routed asserted line
    p_fiq_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_o |-> (src_lvl & en_q & sel_q) != '0);
    // R4: a line is never pending on both paths
    p_paths_apart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (nrm_vec & fst_vec) == '0);
endmodule

// File: tb/drc_intc_tb.sv
module drc_intc_tb;
    import drc_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_lvl = '0;
    logic [2:0]  bus_word = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, fiq_o;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] seed = 32'h1BADB002;

    always #10 clk = ~clk;   // 50 MHz

    drc_intc u_dut (
        .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .bus_word(bus_word),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .fiq_o(fiq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] w, input logic [31:0] d);
        @(negedge clk);
        bus_word = w; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] w, output logic [31:0] d);
        @(negedge clk);
        bus_word = w; bus_we = 1'b0;
        @(negedge clk);
        d = bus_rdata;
    endtask

    function automatic logic [31:0] top_of(input logic [31:0] v);
        for (int i = 0; i < 32; i++)
            if (v[i]) return 32'h8000_0000 | i;
        return 32'h0;
    endfunction

    function automatic logic [31:0] next_rand();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d, en, sel, pr, sr, nrm, fst;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 / R7: reset values
        for (int w = 0; w < 8; w++) begin
            rd(3'(w), d);
            check("R1 reset word", d, 32'h0);
        end
        check("R1 irq after reset", {31'b0, irq_o}, 32'h0);
        check("R1 fiq after reset", {31'b0, fiq_o}, 32'h0);

        // R3: write and read back
        wr(3'd1, 32'hA5A5_0F0F); wr(3'd2, 32'h3C3C_FF00); wr(3'd5, 32'h1234_5678);
        rd(3'd1, d); check("R3 enable readback", d, 32'hA5A5_0F0F);
        rd(3'd2, d); check("R3 select readback", d, 32'h3C3C_FF00);
        rd(3'd5, d); check("R3 priority readback", d, 32'h1234_5678);

        // R8: writes to read-only words
        wr(3'd0, '1); wr(3'd3, '1); wr(3'd4, '1); wr(3'd6, '1); wr(3'd7, '1);
        rd(3'd1, d); check("R8 enable kept", d, 32'hA5A5_0F0F);
        rd(3'd2, d); check("R8 select kept", d, 32'h3C3C_FF00);
        rd(3'd5, d); check("R8 priority kept", d, 32'h1234_5678);
        rd(3'd0, d); check("R8 raw unchanged", d, 32'h0);
        rd(3'd3, d); check("R8 normal pending unchanged", d, 32'h0);
        rd(3'd7, d); check("R8 fast top unchanged", d, 32'h0);
        check("R8 irq low", {31'b0, irq_o}, 32'h0);
        check("R8 fiq low", {31'b0, fiq_o}, 32'h0);

        // R10: asserted but disabled lines
        wr(3'd1, 32'h0);
        @(negedge clk); src_lvl = '1; #1;
        check("R10 irq low", {31'b0, irq_o}, 32'h0);
        check("R10 fiq low", {31'b0, fiq_o}, 32'h0);
        rd(3'd0, d); check("R10 raw visible", d, 32'hFFFF_FFFF);
        rd(3'd6, d); check("R10 normal top empty", d, 32'h0);
        rd(3'd4, d); check("R10 fast pending empty", d, 32'h0);

        // R2: registered read data
        wr(3'd1, '1);
        @(negedge clk); bus_word = 3'd0; src_lvl = 32'h0000_00F0;
        @(posedge clk); #1 src_lvl = 32'h0F00_0000;
        @(negedge clk); check("R2 data from edge", bus_rdata, 32'h0000_00F0);
        @(negedge clk); check("R2 data next edge", bus_rdata, 32'h0F00_0000);

        // R4 / R5 / R6: single-line sweep over both paths
        for (int i = 0; i < 32; i++) begin
            for (int p = 0; p < 2; p++) begin
                sel = (p == 1) ? (32'h1 << i) : ~(32'h1 << i);
                wr(3'd2, sel);
                @(negedge clk); src_lvl = 32'h1 << i; #1;
                check("R5 irq single", {31'b0, irq_o}, {31'b0, p == 0});
                check("R5 fiq single", {31'b0, fiq_o}, {31'b0, p == 1});
                rd(3'd6, d); check("R6 normal top single", d, (p == 0) ? (32'h8000_0000 | i) : 32'h0);
                rd(3'd7, d); check("R6 fast top single", d, (p == 1) ? (32'h8000_0000 | i) : 32'h0);
            end
        end

        // R4 / R6 / R7 / R9 / R10: random patterns
        for (int k = 0; k < 60; k++) begin
            en = next_rand(); sel = next_rand(); pr = next_rand(); sr = next_rand() & next_rand();
            if (k % 10 == 3) sr = 32'h0;
            wr(3'd1, en); wr(3'd2, sel); wr(3'd5, pr);
            @(negedge clk); src_lvl = sr; #1;
            nrm = sr & en & ~sel;
            fst = sr & en & sel;
            check("R5 irq random", {31'b0, irq_o}, {31'b0, nrm != 0});
            check("R5 fiq random", {31'b0, fiq_o}, {31'b0, fst != 0});
            rd(3'd0, d); check("R10 raw random", d, sr);
            rd(3'd3, d); check("R4 normal pending", d, nrm);
            rd(3'd4, d); check("R4 fast pending", d, fst);
            rd(3'd5, d); check("R9 priority kept", d, pr);
            rd(3'd6, d); check("R6 R7 R9 normal top", d, top_of(nrm));
            rd(3'd7, d); check("R6 R7 R9 fast top", d, top_of(fst));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule